// File: doc/BRIEF.md
# RF channel tuning sequencer

This block retunes a 2.4 GHz radio transceiver. A controller pulses `start` with a channel number from 1 to 14, a calibration choice (a standard VCO configuration index or the autocal flag) and a transmit power index. The sequencer then presents an ordered series of 24-bit register-write words on a ready/valid port to a downstream serializer. The serializer shifts each word into the radio's write-only control interface.

Each word carries a 4-bit register address in bits 23:20 and a 20-bit payload in bits 19:0. The payloads come from internal lookup functions: synthesizer value, fractional divide ratio, VCO configuration and transmit gain. After the VCO write, the fixed mode-register sequence is always replayed. A gain write closes the series when the power index is in range. `done` pulses once the last word has been accepted.

The controller is built as a small state machine with these states: IDLE (waiting for start), SYNTH (register 1 word), RATIO (register 2 word), VCO (register 3 word), MODE (four register 0 words, counted by a 2-bit step), GAIN (register 7 word) and FIN (one cycle, asserts done). It takes these transitions:
- IDLE goes to SYNTH on an accepted start.
- SYNTH goes to RATIO, RATIO to VCO and VCO to MODE, each on a handshake.
- MODE stays in MODE until its fourth handshake. It then moves to GAIN, or to FIN when the gain write is skipped.
- GAIN goes to FIN on a handshake.
- FIN always returns to IDLE.

Top module: `rftune_seq`

## Requirements
- R1: Every word puts the register address in bits 23:20 and the payload in bits 19:0.
- R2: An accepted start is followed, in order, by these words:
  - register 1;
  - register 2;
  - register 3;
  - four register 0 words;
  - a register 7 word, when the gain write is not skipped.
- R3: The register 1 payload in standard mode depends on the channel:
  - 0x47 for channels 1 and 2;
  - 0x67 for channels 3 to 6;
  - 0x57 for channels 7 to 10;
  - 0x77 for channels 11 to 13;
  - 0x4f for channel 14.

  In autocal mode the payload is that value ORed with 0x6800.
- R4: The register 2 payload is the same in both modes:
  - 0xccc for channel 14;
  - otherwise it depends on channel mod 4: 0x999 for 1, 0x99b for 2, 0x998 for 3 and 0x99a for 0.
- R5: The register 3 payload is 0x40000 ORed with a 16-bit entry. In autocal mode the entry is 0x6662 for every channel. In standard mode, let p = (channel-1)/2, g = p/2 and c be the configuration index (0 to 10). The entry is formed as follows:
  - The high byte is 0x60 for p=1, 0x64 for p=3 or p=5, and 0x66 otherwise.
  - The low byte is element c+3-g of the list 65,55,75,4d,6d,5d,7d,43,63,53,73,4b,6b,5b (hex).
- R6: The four register 0 payloads are 0x25f98, 0x25f9a, 0x25f94 and 0x27fd4, in that order.
- R7: For a power index from 0x00 to 0x12, the register 7 payload is the gain entry at that index. The entries, from index 0 upward, are 0e313, 0fb13, 0e093, 0f893, 0ea93, 1f093, 1f493, 1f693, 1f393, 1f35b, 1e6db, 1ff3f, 1ffff, 361d7, 37fbf, 3ff8b, 3ff33, 3fb3f, 3ffff (hex).
- R8: A power index of 0x13 or above skips the register 7 word. The series then ends after the fourth register 0 word, and done still pulses.
- R9: `done` is high for exactly one cycle, the cycle after the last word is accepted. `busy` is high from the cycle after an accepted start up to and including that cycle.
- R10: While `cmd_valid` is high and `cmd_ready` is low, the word and `cmd_valid` hold unchanged into the next cycle.
- R11: A start pulse while busy is ignored. The running series continues with its original inputs.
- R12: A start is rejected, with `err` set and no words emitted, in either of these cases:
  - the channel is 0 or above 14;
  - standard mode is selected with a configuration index of 11 or more.

  `err` stays high until the next accepted start clears it.
- R13: After reset, `cmd_valid`, `done`, `busy` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a retune, sampled when idle |
| chan | input | 4 | Channel number, 1 to 14 |
| cfg_idx | input | 4 | Standard VCO configuration index, 0 to 10 |
| use_autocal | input | 1 | Select the autocal synthesizer and VCO words |
| pwr_idx | input | 8 | Transmit gain index for the channel |
| cmd_ready | input | 1 | Downstream serializer accepts the word |
| cmd_valid | output | 1 | A word is presented |
| cmd_word | output | 24 | Address in 23:20, payload in 19:0 |
| busy | output | 1 | A series is in progress |
| done | output | 1 | One-cycle pulse after the last word |
| err | output | 1 | Last start was rejected |

## Verification
A wrong state or a wrong latched input shows up at the ports on the very handshake it affects. It appears as a wrong address (a skipped or repeated state) or a wrong payload (a bad table column or channel pair). Because the words of a series come in strict order, a misstep in the mode counter or in the gain-skip decision changes the word count and moves the done pulse by one cycle. That shift is seen at the end of the same series. The bench sweeps every channel against every calibration choice and walks the power index through all valid values, the boundary and a large value. It does this under varying backpressure, so a table or ordering fault surfaces within one series.

// File: rtl/rftune_pkg.sv
package rftune_pkg;

    localparam int ADDR_W = 4;
    localparam int PAY_W  = 20;
    localparam int WORD_W = ADDR_W + PAY_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNTH,
        ST_RATIO,
        ST_VCO,
        ST_MODE,
        ST_GAIN,
        ST_FIN
    } seq_state_e;

    function automatic logic [7:0] synth_std(input logic [3:0] ch);
        logic [7:0] v;
        case (ch)
            4'd1, 4'd2:                 v = 8'h47;
            4'd3, 4'd4, 4'd5, 4'd6:     v = 8'h67;
            4'd7, 4'd8, 4'd9, 4'd10:    v = 8'h57;
            4'd11, 4'd12, 4'd13:        v = 8'h77;
            default:                    v = 8'h4f;
        endcase
        return v;
    endfunction

    function automatic logic [11:0] divide_ratio(input logic [3:0] ch);
        logic [11:0] v;
        case (ch)
            4'd14:                      v = 12'hccc;
            4'd1, 4'd5, 4'd9, 4'd13:    v = 12'h999;
            4'd2, 4'd6, 4'd10:          v = 12'h99b;
            4'd3, 4'd7, 4'd11:          v = 12'h998;
            default:                    v = 12'h99a;
        endcase
        return v;
    endfunction

    // Low byte of the standard VCO entry; tables are rotations of this list.
    function automatic logic [7:0] vco_low(input logic [4:0] k);
        logic [7:0] v;
        case (k)
            5'd0:    v = 8'h65;
            5'd1:    v = 8'h55;
            5'd2:    v = 8'h75;
            5'd3:    v = 8'h4d;
            5'd4:    v = 8'h6d;
            5'd5:    v = 8'h5d;
            5'd6:    v = 8'h7d;
            5'd7:    v = 8'h43;
            5'd8:    v = 8'h63;
            5'd9:    v = 8'h53;
            5'd10:   v = 8'h73;
            5'd11:   v = 8'h4b;
            5'd12:   v = 8'h6b;
            default: v = 8'h5b;
        endcase
        return v;
    endfunction

    function automatic logic [7:0] vco_high(input logic [2:0] pair);
        logic [7:0] v;
        case (pair)
            3'd1:       v = 8'h60;
            3'd3, 3'd5: v = 8'h64;
            default:    v = 8'h66;
        endcase
        return v;
    endfunction

    function automatic logic [19:0] mode_word(input logic [1:0] n);
        logic [19:0] v;
        case (n)
            2'd0:    v = 20'h25f98;
            2'd1:    v = 20'h25f9a;
            2'd2:    v = 20'h25f94;
            default: v = 20'h27fd4;
        endcase
        return v;
    endfunction

    function automatic logic [19:0] tx_gain(input logic [7:0] idx);
        logic [19:0] v;
        case (idx)
            8'h00:   v = 20'h0e313;
            8'h01:   v = 20'h0fb13;
            8'h02:   v = 20'h0e093;
            8'h03:   v = 20'h0f893;
            8'h04:   v = 20'h0ea93;
            8'h05:   v = 20'h1f093;
            8'h06:   v = 20'h1f493;
            8'h07:   v = 20'h1f693;
            8'h08:   v = 20'h1f393;
            8'h09:   v = 20'h1f35b;
            8'h0a:   v = 20'h1e6db;
            8'h0b:   v = 20'h1ff3f;
            8'h0c:   v = 20'h1ffff;
            8'h0d:   v = 20'h361d7;
            8'h0e:   v = 20'h37fbf;
            8'h0f:   v = 20'h3ff8b;
            8'h10:   v = 20'h3ff33;
            8'h11:   v = 20'h3fb3f;
            8'h12:   v = 20'h3ffff;
            default: v = 20'h00000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rftune_rom.sv
module rftune_rom
    import rftune_pkg::*;
#(
    parameter int CH_W  = 4,
    parameter int CFG_W = 4,
    parameter int PWR_W = 8
) (
    input  seq_state_e        step,
    input  logic [1:0]        mode_n,
    input  logic [CH_W-1:0]   ch,
    input  logic [CFG_W-1:0]  cfg,
    input  logic              autocal,
    input  logic [PWR_W-1:0]  pwr,
    output logic [WORD_W-1:0] word
);
    localparam logic [15:0] AUTOCAL_VCO  = 16'h6662;
    localparam logic [19:0] VCO_RSV_BITS = 20'h40000;
    localparam logic [7:0]  AUTOCAL_SYN  = 8'h68;

    logic [3:0]        ch4;
    logic [3:0]        ch_m1;
    logic [2:0]        pair;
    logic [1:0]        grp;
    logic [4:0]        rot_k;
    logic [7:0]        syn;
    logic [15:0]       vco_entry;
    logic [ADDR_W-1:0] addr;
    logic [PAY_W-1:0]  pay;

    always_comb begin
        ch4       = 4'(ch);
        ch_m1     = ch4 - 4'd1;
        pair      = ch_m1[3:1];
        grp       = pair[2:1];
        rot_k     = 5'(cfg) + 5'd3 - 5'(grp);
        syn       = synth_std(ch4);
        vco_entry = autocal ? AUTOCAL_VCO : {vco_high(pair), vco_low(rot_k)};
    end

    always_comb begin
        addr = '0;
        pay  = '0;
        unique case (step)
            ST_SYNTH: begin
                addr = 4'd1;
                pay  = {4'h0, (autocal ? AUTOCAL_SYN : 8'h00), syn};
            end
            ST_RATIO: begin
                addr = 4'd2;
                pay  = {8'h00, divide_ratio(ch4)};
            end
            ST_VCO: begin
                addr = 4'd3;
                pay  = VCO_RSV_BITS | {4'h0, vco_entry};
            end
            ST_MODE: begin
                addr = 4'd0;
                pay  = mode_word(mode_n);
            end
            ST_GAIN: begin
                addr = 4'd7;
                pay  = tx_gain(8'(pwr));
            end
            default: begin
                addr = '0;
                pay  = '0;
            end
        endcase
    end

    assign word = {addr, pay};

endmodule

// File: rtl/rftune_fsm.sv
module rftune_fsm
    import rftune_pkg::*;
#(
    parameter int CH_W     = 4,
    parameter int CFG_W    = 4,
    parameter int PWR_W    = 8,
    parameter int MAX_CH   = 14,
    parameter int NUM_CFG  = 11,
    parameter int NUM_GAIN = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CH_W-1:0]  chan,
    input  logic [CFG_W-1:0] cfg_idx,
    input  logic             use_autocal,
    input  logic [PWR_W-1:0] pwr_idx,
    input  logic             cmd_ready,
    output seq_state_e       state,
    output logic [1:0]       mode_n,
    output logic [CH_W-1:0]  ch_q,
    output logic [CFG_W-1:0] cfg_q,
    output logic             ac_q,
    output logic [PWR_W-1:0] pwr_q,
    output logic             cmd_valid,
    output logic             busy,
    output logic             done,
    output logic             err
);
    localparam logic [1:0] LAST_MODE = 2'd3;

    seq_state_e state_nx;
    logic       req_bad;
    logic       accept;
    logic       gain_ok;
    logic       err_q;
    logic       hs;

    always_comb begin
        req_bad = (int'(chan) == 0) || (int'(chan) > MAX_CH) ||
                  (!use_autocal && (int'(cfg_idx) >= NUM_CFG));
        accept  = (state == ST_IDLE) && start && !req_bad;
        gain_ok = int'(pwr_q) < NUM_GAIN;
        hs      = cmd_valid && cmd_ready;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_SYNTH;
            ST_SYNTH: if (cmd_ready) state_nx = ST_RATIO;
            ST_RATIO: if (cmd_ready) state_nx = ST_VCO;
            ST_VCO:   if (cmd_ready) state_nx = ST_MODE;
            ST_MODE:  if (cmd_ready && mode_n == LAST_MODE)
                          state_nx = gain_ok ? ST_GAIN : ST_FIN;
            ST_GAIN:  if (cmd_ready) state_nx = ST_FIN;
            ST_FIN:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // captured request, mode step and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q   <= '0;
            cfg_q  <= '0;
            ac_q   <= 1'b0;
            pwr_q  <= '0;
            mode_n <= '0;
            err_q  <= 1'b0;
        end else begin
            if (accept) begin
                ch_q  <= chan;
                cfg_q <= cfg_idx;
                ac_q  <= use_autocal;
                pwr_q <= pwr_idx;
                err_q <= 1'b0;
            end else if (state == ST_IDLE && start) begin
                err_q <= 1'b1;
            end
            if (state == ST_VCO) begin
                mode_n <= '0;
            end else if (state == ST_MODE && hs) begin
                mode_n <= mode_n + 2'd1;
            end
        end
    end

    // outputs
    always_comb begin
        cmd_valid = (state == ST_SYNTH) || (state == ST_RATIO) || (state == ST_VCO) ||
                    (state == ST_MODE)  || (state == ST_GAIN);
        busy      = (state != ST_IDLE);
        done      = (state == ST_FIN);
        err       = err_q;
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !cmd_valid);

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(ch_q) && $stable(cfg_q) && $stable(ac_q) && $stable(pwr_q)));

    assert_gain_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MODE && mode_n == LAST_MODE && cmd_ready && !gain_ok) |=> done);

endmodule

// File: rtl/rftune_seq.sv
module rftune_seq
    import rftune_pkg::*;
#(
    parameter int CH_W     = 4,
    parameter int CFG_W    = 4,
    parameter int PWR_W    = 8,
    parameter int MAX_CH   = 14,
    parameter int NUM_CFG  = 11,
    parameter int NUM_GAIN = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CH_W-1:0]   chan,
    input  logic [CFG_W-1:0]  cfg_idx,
    input  logic              use_autocal,
    input  logic [PWR_W-1:0]  pwr_idx,
    input  logic              cmd_ready,
    output logic              cmd_valid,
    output logic [WORD_W-1:0] cmd_word,
    output logic              busy,
    output logic              done,
    output logic              err
);
    seq_state_e       state;
    logic [1:0]       mode_n;
    logic [CH_W-1:0]  ch_q;
    logic [CFG_W-1:0] cfg_q;
    logic             ac_q;
    logic [PWR_W-1:0] pwr_q;

    rftune_fsm #(
        .CH_W(CH_W), .CFG_W(CFG_W), .PWR_W(PWR_W),
        .MAX_CH(MAX_CH), .NUM_CFG(NUM_CFG), .NUM_GAIN(NUM_GAIN)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .chan(chan), .cfg_idx(cfg_idx), .use_autocal(use_autocal), .pwr_idx(pwr_idx),
        .cmd_ready(cmd_ready),
        .state(state), .mode_n(mode_n),
        .ch_q(ch_q), .cfg_q(cfg_q), .ac_q(ac_q), .pwr_q(pwr_q),
        .cmd_valid(cmd_valid), .busy(busy), .done(done), .err(err)
    );

    rftune_rom #(
        .CH_W(CH_W), .CFG_W(CFG_W), .PWR_W(PWR_W)
    ) u_rom (
        .step(state), .mode_n(mode_n),
        .ch(ch_q), .cfg(cfg_q), .autocal(ac_q), .pwr(pwr_q),
        .word(cmd_word)
    );

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_word)));

    assert_first_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> (cmd_word[23:20] == 4'd1));

    assert_vco_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[23:20] == 4'd3) |-> (cmd_word[19:16] == 4'h4));

    assert_addr_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_word[23:20] inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd7}));

endmodule

// File: tb/rftune_seq_bench.sv
module rftune_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  chan = '0;
    logic [3:0]  cfg_idx = '0;
    logic        use_autocal = 1'b0;
    logic [7:0]  pwr_idx = '0;
    logic        cmd_ready = 1'b0;
    logic        cmd_valid;
    logic [23:0] cmd_word;
    logic        busy, done, err;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) cyc++;

    rftune_seq u_rftune_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .cfg_idx(cfg_idx),
        .use_autocal(use_autocal), .pwr_idx(pwr_idx), .cmd_ready(cmd_ready),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .busy(busy), .done(done), .err(err)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int e_syn(input int ch);
        if (ch <= 2) return 'h47;
        if (ch <= 6) return 'h67;
        if (ch <= 10) return 'h57;
        if (ch <= 13) return 'h77;
        return 'h4f;
    endfunction

    function automatic int e_div(input int ch);
        if (ch == 14) return 'hccc;
        case (ch % 4)
            1: return 'h999;
            2: return 'h99b;
            3: return 'h998;
            default: return 'h99a;
        endcase
    endfunction

    function automatic int e_rot(input int k);
        int lst[14] = '{'h65, 'h55, 'h75, 'h4d, 'h6d, 'h5d, 'h7d, 'h43, 'h63, 'h53, 'h73, 'h4b, 'h6b, 'h5b};
        return lst[k];
    endfunction

    function automatic int e_vco(input int ch, input int cfg, input bit ac);
        int p, g, hi;
        if (ac) return 'h6662;
        p  = (ch - 1) / 2;
        g  = p / 2;
        hi = (p == 1) ? 'h60 : ((p == 3 || p == 5) ? 'h64 : 'h66);
        return (hi << 8) | e_rot(cfg + 3 - g);
    endfunction

    function automatic int e_gain(input int idx);
        int lst[19] = '{'h0e313, 'h0fb13, 'h0e093, 'h0f893, 'h0ea93, 'h1f093, 'h1f493,
                        'h1f693, 'h1f393, 'h1f35b, 'h1e6db, 'h1ff3f, 'h1ffff, 'h361d7,
                        'h37fbf, 'h3ff8b, 'h3ff33, 'h3fb3f, 'h3ffff};
        return lst[idx];
    endfunction

    function automatic int e_word(input int ch, input int cfg, input bit ac, input int pwr, input int n);
        int md[4] = '{'h25f98, 'h25f9a, 'h25f94, 'h27fd4};
        case (n)
            0: return (1 << 20) | e_syn(ch) | (ac ? 'h6800 : 0);
            1: return (2 << 20) | e_div(ch);
            2: return (3 << 20) | 'h40000 | e_vco(ch, cfg, ac);
            3, 4, 5, 6: return md[n-3];
            default: return (7 << 20) | e_gain(pwr);
        endcase
    endfunction

    function automatic string wtag(input int n);
        case (n)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3, 4, 5, 6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic run_seq(input int ch, input int cfg, input bit ac, input int pwr,
                           input bit bp, input bit inject);
        int nw;
        nw = (pwr < 19) ? 8 : 7;
        @(negedge clk);
        start = 1'b1; chan = 4'(ch); cfg_idx = 4'(cfg); use_autocal = ac; pwr_idx = 8'(pwr);
        @(negedge clk);
        start = 1'b0;
        check("R9 busy after start", busy, 1);
        check("R12 err cleared by accepted start", err, 0);
        if (inject) begin
            // R11: a start while busy must not disturb the series
            start = 1'b1; chan = 4'((ch % 14) + 1); cfg_idx = 4'((cfg + 1) % 11);
            use_autocal = ~ac; pwr_idx = 8'h00;
        end
        for (int n = 0; n < nw; n++) begin
            bit          held;
            logic [23:0] hw;
            held = 1'b0;
            for (int w = 0; w < 40; w++) begin
                cmd_ready = bp ? (((cyc % 7) != 3) && ((cyc % 5) != 1)) : 1'b1;
                if (held) check("R10 word held under backpressure", cmd_word, hw);
                if (!cmd_valid) begin
                    check("R2 valid during series", cmd_valid, 1);
                    break;
                end
                if (cmd_ready) begin
                    check({wtag(n), (inject ? " R11" : ""), " R2 R1 word"}, cmd_word,
                          e_word(ch, cfg, ac, pwr, n));
                    @(negedge clk);
                    start = 1'b0;
                    break;
                end
                held = 1'b1; hw = cmd_word;
                @(negedge clk);
                start = 1'b0;
            end
        end
        cmd_ready = 1'b0;
        check((nw == 7) ? "R8 done after skipped gain" : "R9 done after last word", done, 1);
        check("R2 no extra word", cmd_valid, 0);
        @(negedge clk);
        check("R9 done one cycle", done, 0);
        check("R9 busy cleared", busy, 0);
    endtask

    task automatic reject(input int ch, input int cfg, input bit ac);
        @(negedge clk);
        start = 1'b1; chan = 4'(ch); cfg_idx = 4'(cfg); use_autocal = ac; pwr_idx = 8'h00;
        cmd_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R12 err set", err, 1);
        for (int i = 0; i < 4; i++) begin
            check("R12 no words", cmd_valid, 0);
            check("R12 not busy", busy, 0);
            @(negedge clk);
        end
        cmd_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R13 valid at reset", cmd_valid, 0);
        check("R13 done at reset", done, 0);
        check("R13 busy at reset", busy, 0);
        check("R13 err at reset", err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13 idle after reset", cmd_valid, 0);

        for (int ch = 1; ch <= 14; ch++) begin
            for (int c = 0; c <= 11; c++) begin
                int sel, pwr;
                sel = (ch * 7 + c * 3) % 21;
                pwr = (sel < 19) ? sel : ((sel == 19) ? 'h13 : 'hff);
                run_seq(ch, (c == 11) ? 15 : c, c == 11, pwr, ((ch + c) % 2) == 1, c == 5);
            end
        end
        for (int p = 0; p < 19; p++) run_seq(6, 4, 1'b0, p, 1'b0, 1'b0);
        run_seq(14, 10, 1'b0, 'h13, 1'b1, 1'b0);

        reject(0, 0, 1'b0);
        run_seq(3, 2, 1'b0, 5, 1'b0, 1'b0);
        reject(15, 0, 1'b1);
        reject(7, 11, 1'b0);
        run_seq(13, 0, 1'b0, 'h12, 1'b1, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R9 actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule